// File: doc/BRIEF.md
# Load-Use Stall Controller

This block watches the two youngest occupied stages of a five-stage in-order pipeline. It holds back the front end for exactly one cycle when the instruction in decode needs a register that a load in execute has not yet brought back from memory. The detection term is combinational. It compares the destination of the instruction in execute with the two source fields of the instruction in decode, and it only counts the match when the execute instruction reads memory and its destination is not the hardwired-zero register.

One stall term drives three enables together: the fetch address register write, the decode register write and the execute control select. When the select drops, the execute stage receives an all-zero control bundle, which is a bubble. The decode instruction stays where it is and retries on the next cycle. The fetch address does not move, so fetch reads the same word again and the decode register is left unchanged. The unit has a thin pipeline shell around it: the fetch address register, the decode instruction register and the execute control register. This shell makes freezing and bubble insertion visible at the ports. An outside instruction store answers `fetch_addr` with `fetch_word` in the same cycle.

Instruction word layout, `INSTR_W = 2 + 3*REG_W` bits (17 at defaults): bit 16 is memory read (load), bit 15 is register write, bits 14:10 are the destination, bits 9:5 are source A and bits 4:0 are source B. The all-zero word is a NOP. The execute control bundle is bits 16:10 of the decode word.

Top module: `loaduse_stall_ctl`

## Requirements
- R1: `stall` is 1 when the execute bundle has memory read 1, a nonzero destination, and that destination equals source A (bits 9:5) of the decode word.
- R2: `stall` is 1 under the same load conditions when the destination equals source B (bits 4:0) of the decode word.
- R3: A load whose destination is register 0 never raises `stall`, even if a decode source field is also 0.
- R4: An execute instruction with memory read 0 never raises `stall`, whatever its destination is. A load whose destination matches neither decode source also leaves `stall` at 0.
- R5: `pc_we`, `ifid_we` and `ctl_sel` are all 0 while `stall` is 1, and all 1 while `stall` is 0.
- R6: On a clock edge with `stall` 1, the execute bundle becomes all zero (a bubble) and `id_word` keeps its value.
- R7: On a clock edge with `stall` 1, `fetch_addr` keeps its value. After the stall the same address is fetched again.
- R8: Each load-use hazard costs exactly one bubble. `stall` is never 1 on two consecutive cycles. In a chain of dependent loads, each dependent pair costs its own single stall.
- R9: If one independent instruction sits between a load and its user, no stall occurs and the three instructions reach execute on consecutive cycles.
- R10: While `rst_n` is 0, `fetch_addr` is 0, `id_word` is 0 and the execute bundle is 0.
- R11: On a clock edge with `stall` 0, `fetch_addr` advances by 4, `id_word` takes `fetch_word`, and the execute bundle takes bits 16:10 of the previous `id_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | 8 | Byte address of the word being fetched |
| fetch_word | input | 17 | Instruction word returned for `fetch_addr` |
| id_word | output | 17 | Instruction held in the decode register |
| ex_mem_read | output | 1 | Memory-read bit of the execute bundle |
| ex_reg_write | output | 1 | Register-write bit of the execute bundle |
| ex_dest | output | 5 | Destination field of the execute bundle |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_we | output | 1 | Fetch address write enable |
| ifid_we | output | 1 | Decode register write enable |
| ctl_sel | output | 1 | 1 passes decoded control to execute, 0 injects a bubble |

## Verification
The properties assume that the instruction store returns a fully defined word for every address within one cycle. They also assume that reset is held for at least one clock edge, so that the shell starts from NOPs. The bench guarantees both: it serves every address from a zero-filled array and writes each program only while reset is asserted. Every scenario is a short straight-line program, and the array beyond the program holds NOPs, so wrap-around of the fetch address is never reached and fetch always has well-defined data.

// File: rtl/loaduse_stall_ctl.sv
module loaduse_stall_ctl #(
  parameter int REG_W   = 5,
  parameter int PC_W    = 8,
  parameter int PC_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [PC_W-1:0]      fetch_addr,
  input  logic [2+3*REG_W-1:0] fetch_word,
  output logic [2+3*REG_W-1:0] id_word,
  output logic                 ex_mem_read,
  output logic                 ex_reg_write,
  output logic [REG_W-1:0]     ex_dest,
  output logic                 stall,
  output logic                 pc_we,
  output logic                 ifid_we,
  output logic                 ctl_sel
);
  localparam int INSTR_W = 2 + 3*REG_W;
  localparam int CTL_W   = 2 + REG_W;
  localparam int SB_LO   = 0;
  localparam int SA_LO   = REG_W;
  localparam int DST_LO  = 2*REG_W;
  localparam int WR_BIT  = 3*REG_W;
  localparam int RD_BIT  = 3*REG_W + 1;

  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] ifid_q;
  logic [CTL_W-1:0]   idex_q;
  logic [CTL_W-1:0]   id_ctl;
  logic [REG_W-1:0]   id_src_a, id_src_b;
  logic               dst_live, hit_a, hit_b;

  assign id_src_a = ifid_q[SA_LO +: REG_W];
  assign id_src_b = ifid_q[SB_LO +: REG_W];
  assign id_ctl   = ifid_q[RD_BIT:DST_LO];

  assign ex_mem_read  = idex_q[CTL_W-1];
  assign ex_reg_write = idex_q[CTL_W-2];
  assign ex_dest      = idex_q[REG_W-1:0];

  assign dst_live = ex_mem_read && (ex_dest != '0);
  assign hit_a    = (ex_dest == id_src_a);
  assign hit_b    = (ex_dest == id_src_b);
  assign stall    = dst_live && (hit_a || hit_b);

  assign pc_we   = ~stall;
  assign ifid_we = ~stall;
  assign ctl_sel = ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (pc_we) pc_q <= pc_q + PC_W'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ifid_q <= '0;
    else if (ifid_we) ifid_q <= fetch_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idex_q <= '0;
    else idex_q <= ctl_sel ? id_ctl : '0;
  end

  assign fetch_addr = pc_q;
  assign id_word    = ifid_q;

  logic unused_wr;
  assign unused_wr = ifid_q[WR_BIT];
endmodule

// File: rtl/loaduse_stall_chk.sv
module loaduse_stall_chk #(
  parameter int REG_W   = 5,
  parameter int PC_W    = 8,
  parameter int PC_STEP = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PC_W-1:0]      fetch_addr,
  input logic [2+3*REG_W-1:0] id_word,
  input logic                 ex_mem_read,
  input logic                 ex_reg_write,
  input logic [REG_W-1:0]     ex_dest,
  input logic                 stall,
  input logic                 pc_we,
  input logic                 ifid_we,
  input logic                 ctl_sel
);
  // R5
  enables_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == ifid_we) && (ifid_we == ctl_sel) && (ctl_sel != stall));

  // R6
  bubble_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex_mem_read && !ex_reg_write && ex_dest == '0));

  // R6
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(id_word));

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_addr));

  // R3
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dest == '0) |-> !stall);

  // R4
  no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_read |-> !stall);

  // R8
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R11
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> fetch_addr == $past(fetch_addr) + PC_W'(PC_STEP));
endmodule

bind loaduse_stall_ctl loaduse_stall_chk #(
  .REG_W(REG_W), .PC_W(PC_W), .PC_STEP(PC_STEP)
) u_loaduse_stall_chk (
  .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .id_word(id_word),
  .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write), .ex_dest(ex_dest),
  .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we), .ctl_sel(ctl_sel)
);

// File: tb/test_loaduse_stall_ctl.sv
`timescale 1ns/1ps
module test_loaduse_stall_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  fetch_addr;
  logic [16:0] fetch_word;
  logic [16:0] id_word;
  logic        ex_mem_read, ex_reg_write;
  logic [4:0]  ex_dest;
  logic        stall, pc_we, ifid_we, ctl_sel;

  int checks = 0;
  int failures = 0;

  logic [16:0] prog [64];

  logic [7:0]  q_pc [$];
  logic [16:0] q_idw [$];
  logic [6:0]  q_ex [$];
  logic        q_st [$];
  string       q_req [$];

  always #10 clk = ~clk;

  assign fetch_word = prog[fetch_addr[7:2]];

  loaduse_stall_ctl i_loaduse_stall_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .id_word(id_word), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
    .ex_dest(ex_dest), .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we),
    .ctl_sel(ctl_sel)
  );

  function automatic logic [16:0] mk(bit ld, bit wr, int d, int a, int b);
    return {ld, wr, 5'(d), 5'(a), 5'(b)};
  endfunction

  function automatic logic [6:0] ctl(logic [16:0] w);
    return w[16:10];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] pc, logic [16:0] idw, logic [16:0] exw, logic st, string req);
    q_pc.push_back(pc);
    q_idw.push_back(idw);
    q_ex.push_back(ctl(exw));
    q_st.push_back(st);
    q_req.push_back(req);
  endtask

  task automatic start_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) prog[i] = '0;
  endtask

  task automatic run_prog();
    @(negedge clk);
    #2 rst_n = 1'b1;
    while (q_pc.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && q_pc.size() != 0) begin
      logic [7:0] e_pc;
      logic [16:0] e_idw;
      logic [6:0] e_ex;
      logic e_st;
      string r;
      e_pc = q_pc.pop_front();
      e_idw = q_idw.pop_front();
      e_ex = q_ex.pop_front();
      e_st = q_st.pop_front();
      r = q_req.pop_front();
      check(r, "fetch_addr", 32'(fetch_addr), 32'(e_pc));
      check(r, "id_word", 32'(id_word), 32'(e_idw));
      check(r, "ex_bundle", 32'({ex_mem_read, ex_reg_write, ex_dest}), 32'(e_ex));
      check(r, "stall", 32'(stall), 32'(e_st));
      // R5
      check("R5", "enables", 32'({pc_we, ifid_we, ctl_sel}), e_st ? 32'h0 : 32'h7);
    end
  end

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [16:0] lw2, add_a, add_b, lw0, use0, l1, l2, add3, sub6, alu2, addx;
    for (int i = 0; i < 64; i++) prog[i] = '0;
    lw2   = mk(1, 1, 2, 1, 0);
    add_a = mk(0, 1, 4, 2, 5);
    add_b = mk(0, 1, 4, 5, 2);
    lw0   = mk(1, 1, 0, 1, 0);
    use0  = mk(0, 1, 4, 0, 0);
    l1    = mk(1, 1, 2, 1, 0);
    l2    = mk(1, 1, 3, 2, 0);
    add3  = mk(0, 1, 4, 3, 2);
    sub6  = mk(0, 1, 6, 7, 8);
    alu2  = mk(0, 1, 2, 3, 3);
    addx  = mk(0, 1, 4, 3, 5);

    // R10 reset state
    repeat (2) @(negedge clk);
    check("R10", "fetch_addr", 32'(fetch_addr), 0);
    check("R10", "id_word", 32'(id_word), 0);
    check("R10", "ex_bundle", 32'({ex_mem_read, ex_reg_write, ex_dest}), 0);

    // R1 R6 R7 R8: load then use on source A, one bubble, refetch of same address
    start_prog(); prog[0] = lw2; prog[1] = add_a;
    push(8'd4,  lw2,   '0,    0, "R11");
    push(8'd8,  add_a, lw2,   1, "R1");
    push(8'd8,  add_a, '0,    0, "R6");
    push(8'd12, '0,    add_a, 0, "R8");
    push(8'd16, '0,    '0,    0, "R8");
    run_prog();

    // R2: match on source B
    start_prog(); prog[0] = lw2; prog[1] = add_b;
    push(8'd4,  lw2,   '0,    0, "R11");
    push(8'd8,  add_b, lw2,   1, "R2");
    push(8'd8,  add_b, '0,    0, "R7");
    push(8'd12, '0,    add_b, 0, "R2");
    run_prog();

    // R3: load into register 0, user reads register 0
    start_prog(); prog[0] = lw0; prog[1] = use0;
    push(8'd4,  lw0,  '0,   0, "R3");
    push(8'd8,  use0, lw0,  0, "R3");
    push(8'd12, '0,   use0, 0, "R3");
    run_prog();

    // R4: non-load writer then user of its destination
    start_prog(); prog[0] = alu2; prog[1] = add_a;
    push(8'd4,  alu2,  '0,    0, "R4");
    push(8'd8,  add_a, alu2,  0, "R4");
    push(8'd12, '0,    add_a, 0, "R4");
    run_prog();

    // R4: load whose destination matches neither source
    start_prog(); prog[0] = lw2; prog[1] = addx;
    push(8'd4,  lw2,  '0,   0, "R4");
    push(8'd8,  addx, lw2,  0, "R4");
    push(8'd12, '0,   addx, 0, "R4");
    run_prog();

    // R8: chained dependent loads, two separate single stalls
    start_prog(); prog[0] = l1; prog[1] = l2; prog[2] = add3;
    push(8'd4,  l1,   '0,   0, "R8");
    push(8'd8,  l2,   l1,   1, "R8");
    push(8'd8,  l2,   '0,   0, "R8");
    push(8'd12, add3, l2,   1, "R8");
    push(8'd12, add3, '0,   0, "R8");
    push(8'd16, '0,   add3, 0, "R8");
    push(8'd20, '0,   '0,   0, "R8");
    run_prog();

    // R9: independent instruction between load and use
    start_prog(); prog[0] = lw2; prog[1] = sub6; prog[2] = add_a;
    push(8'd4,  lw2,   '0,    0, "R9");
    push(8'd8,  sub6,  lw2,   0, "R9");
    push(8'd12, add_a, sub6,  0, "R9");
    push(8'd16, '0,    add_a, 0, "R9");
    run_prog();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule